// File: doc/BRIEF.md
# Eight-Bit GPIO Port with Synchronized Pin Input

This block is one general-purpose I/O port seen from a small controller's register bus. Software sets a direction bit and an output bit for each pin. The block turns these settings into three pad controls per pin: a drive value, a drive enable and a weak pull-up enable. Two separate inputs can block the pull-up: a chip-wide disable and a disable for this port only. Setting either one turns off every pull-up on the port.

Each pad level is read back through a two-stage input path. The first stage holds the pad level as it stands at the falling clock edge. A rising-edge flop then loads that level into the pin-input register. An external transition therefore reaches software between half a clock period and one and a half clock periods after it happens, depending on its phase. A value that software drives onto the pad is readable one full period after the write edge.

The bus is single-cycle and has no handshake. A write completes on the rising edge where the write enable is high. Read data is a combinational function of the address. The reset input clears everything asynchronously. Its release is resynchronized to the clock.

Top module: `gpio_port`

## Requirements
- R1: While reset is asserted, the direction, output and pin-input registers read zero, and every drive enable and pull-up enable is low.
- R2: A write with address 1 loads the direction register and a write with address 2 loads the output register on that rising edge. Each register reads back on the same address. Address 3 reads as zero.
- R3: A write to address 0, the pin-input register, changes no register. A pad capture on the same edge still lands in the pin-input register.
- R4: Each pin's drive enable equals its direction bit. Its drive value equals its output bit.
- R5: A pin's pull-up is on exactly when its direction bit is 0, its output bit is 1, and both the chip-wide and the port-wide disable inputs are low.
- R6: The pin-input register samples the pad level of every pin, whatever its direction bit. Driven pins read their own output and undriven pins read the external level.
- R7: A pad change during the high clock phase shows in the pin-input register after the next rising edge. A change during the low phase shows only after the second rising edge.
- R8: After a write to the output register of a driven pin, a read of the pin-input register before the next rising edge returns the old level. A read after that edge returns the new level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_we | input | 1 | Write strobe for the addressed register |
| bus_addr | input | 2 | Register select: 0 pin input, 1 direction, 2 output, 3 unused |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the addressed register |
| pud_global | input | 1 | Chip-wide pull-up disable |
| pud_port | input | 1 | Port-wide pull-up disable |
| pad_in | input | 8 | Resolved pad levels |
| pad_out | output | 8 | Drive value per pin |
| pad_oe | output | 8 | Drive enable per pin |
| pad_pu | output | 8 | Pull-up enable per pin |

## Verification
Two functions can land on the same rising edge: a bus write, and the capture of a new pad level into the pin-input register. The bench forces this case in two ways. First, it changes the external level in the high phase just before an ignored write to address 0, and checks that the read-back pin value shows the new pad level and not the write data. Second, it writes a driven output and reads the pin register before and after the following edge, which tells a write that reaches the input path too early apart from one that reaches it on time. A sweep over all direction patterns, several output patterns and all four disable combinations judges the drive, enable, pull-up and sampled pin values against values the bench computes from R4 to R6.

// File: rtl/gpio_pkg.sv
`timescale 1ns/1ps
package gpio_pkg;
  localparam int unsigned SEL_W = 2;

  typedef enum logic [SEL_W-1:0] {
    SEL_PIN  = 2'd0,
    SEL_DIR  = 2'd1,
    SEL_OUT  = 2'd2,
    SEL_NONE = 2'd3
  } gpio_sel_e;
endpackage

// File: rtl/gpio_rst_sync.sv
`timescale 1ns/1ps
module gpio_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  localparam int unsigned LAST = STAGES - 1;

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[LAST-1:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[LAST];
endmodule

// File: rtl/gpio_regs.sv
`timescale 1ns/1ps
module gpio_regs
  import gpio_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [SEL_W-1:0] addr,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] dir_q,
  output logic [WIDTH-1:0] out_q
);
  logic             dir_en;
  logic             out_en;
  logic [WIDTH-1:0] dir_d;
  logic [WIDTH-1:0] out_d;

  always_comb begin
    dir_en = we && (addr == SEL_DIR);
    out_en = we && (addr == SEL_OUT);
    dir_d  = wdata;
    out_d  = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dir_q <= '0;
    else if (dir_en) dir_q <= dir_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      out_q <= '0;
    else if (out_en) out_q <= out_d;
  end
endmodule

// File: rtl/gpio_pad_ctl.sv
`timescale 1ns/1ps
module gpio_pad_ctl #(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] dir_q,
  input  logic [WIDTH-1:0] out_q,
  input  logic             pu_block,
  output logic [WIDTH-1:0] drv_val,
  output logic [WIDTH-1:0] drv_en,
  output logic [WIDTH-1:0] pu_en
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    always_comb begin
      drv_en[b]  = dir_q[b];
      drv_val[b] = out_q[b];
      // Pull-up only on an input pin whose output bit is set and not blocked
      pu_en[b]   = !dir_q[b] && out_q[b] && !pu_block;
    end
  end
endmodule

// File: rtl/gpio_in_sync.sv
`timescale 1ns/1ps
module gpio_in_sync #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pad_lvl,
  output logic [WIDTH-1:0] pin_q
);
  logic [WIDTH-1:0] hold_q;

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    // First stage: carries the pad level present at the falling edge
    // through the low phase, as a high-transparent latch would.
    always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) hold_q[b] <= 1'b0;
      else        hold_q[b] <= pad_lvl[b];
    end

    // Second stage: rising-edge capture into the pin-input register.
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pin_q[b] <= 1'b0;
      else        pin_q[b] <= hold_q[b];
    end
  end
endmodule

// File: rtl/gpio_port.sv
`timescale 1ns/1ps
module gpio_port
  import gpio_pkg::*;
#(
  parameter int unsigned WIDTH     = 8,
  parameter int unsigned RST_STAGE = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_we,
  input  logic [SEL_W-1:0] bus_addr,
  input  logic [WIDTH-1:0] bus_wdata,
  output logic [WIDTH-1:0] bus_rdata,
  input  logic             pud_global,
  input  logic             pud_port,
  input  logic [WIDTH-1:0] pad_in,
  output logic [WIDTH-1:0] pad_out,
  output logic [WIDTH-1:0] pad_oe,
  output logic [WIDTH-1:0] pad_pu
);
  logic             rst_sync_n;
  logic [WIDTH-1:0] dir_q;
  logic [WIDTH-1:0] out_q;
  logic [WIDTH-1:0] pin_q;
  logic             pu_block;

  gpio_rst_sync #(.STAGES(RST_STAGE)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  gpio_regs #(.WIDTH(WIDTH)) u_regs (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .we    (bus_we),
    .addr  (bus_addr),
    .wdata (bus_wdata),
    .dir_q (dir_q),
    .out_q (out_q)
  );

  always_comb begin
    pu_block = pud_global || pud_port;
  end

  gpio_pad_ctl #(.WIDTH(WIDTH)) u_pad (
    .dir_q    (dir_q),
    .out_q    (out_q),
    .pu_block (pu_block),
    .drv_val  (pad_out),
    .drv_en   (pad_oe),
    .pu_en    (pad_pu)
  );

  gpio_in_sync #(.WIDTH(WIDTH)) u_sync (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .pad_lvl (pad_in),
    .pin_q   (pin_q)
  );

  always_comb begin
    unique case (bus_addr)
      SEL_PIN: bus_rdata = pin_q;
      SEL_DIR: bus_rdata = dir_q;
      SEL_OUT: bus_rdata = out_q;
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/gpio_port_chk.sv
`timescale 1ns/1ps
module gpio_port_chk
  import gpio_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rst_sync_n,
  input logic             bus_we,
  input logic [SEL_W-1:0] bus_addr,
  input logic [WIDTH-1:0] bus_wdata,
  input logic             pud_global,
  input logic             pud_port,
  input logic [WIDTH-1:0] pad_out,
  input logic [WIDTH-1:0] pad_oe,
  input logic [WIDTH-1:0] pad_pu
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |-> (pad_oe == '0 && pad_pu == '0));

  // R2
  out_write_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_we && bus_addr == SEL_OUT) |=> (pad_out == $past(bus_wdata)));

  // R4
  dir_write_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_we && bus_addr == SEL_DIR) |=> (pad_oe == $past(bus_wdata)));

  // R3
  pin_addr_write_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_we && bus_addr == SEL_PIN) |=> ($stable(pad_oe) && $stable(pad_out)));

  // R5
  pu_blocked_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (pud_global || pud_port) |-> (pad_pu == '0));

  // R5
  pu_vs_drive_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((pad_pu & pad_oe) == '0) && ((pad_pu & ~pad_out) == '0));
endmodule

bind gpio_port gpio_port_chk #(.WIDTH(WIDTH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rst_sync_n (rst_sync_n),
  .bus_we     (bus_we),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .pud_global (pud_global),
  .pud_port   (pud_port),
  .pad_out    (pad_out),
  .pad_oe     (pad_oe),
  .pad_pu     (pad_pu)
);

// File: tb/gpio_port_bench.sv
`timescale 1ns/1ps
module gpio_port_bench;
  localparam int W = 8;

  logic         clk;
  logic         rst_n;
  logic         bus_we;
  logic [1:0]   bus_addr;
  logic [W-1:0] bus_wdata;
  logic [W-1:0] bus_rdata;
  logic         pud_global;
  logic         pud_port;
  logic [W-1:0] pad_in;
  logic [W-1:0] pad_out;
  logic [W-1:0] pad_oe;
  logic [W-1:0] pad_pu;
  logic [W-1:0] ext_drv;
  logic [W-1:0] ext_val;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  gpio_port u_gpio_port (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pud_global(pud_global),
    .pud_port(pud_port), .pad_in(pad_in), .pad_out(pad_out),
    .pad_oe(pad_oe), .pad_pu(pad_pu)
  );

  // 250 MHz
  initial clk = 1'b0;
  always #2 clk = ~clk;

  // Pad resolution: own drive wins, else external driver, else pull-up or low
  always_comb begin
    for (int i = 0; i < W; i++) begin
      if (pad_oe[i])       pad_in[i] = pad_out[i];
      else if (ext_drv[i]) pad_in[i] = ext_val[i];
      else                 pad_in[i] = pad_pu[i];
    end
  end

  task automatic check(input string req, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [W-1:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    #1;
    bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [W-1:0] v);
    bus_addr = a;
    #0.2;
    v = bus_rdata;
  endtask

  function automatic logic [W-1:0] exp_pu(input logic [W-1:0] d,
      input logic [W-1:0] o, input logic g, input logic p);
    return (~d) & o & {W{~(g | p)}};
  endfunction

  function automatic logic [W-1:0] exp_pin(input logic [W-1:0] d,
      input logic [W-1:0] o, input logic g, input logic p);
    return (d & o) | (~d & ext_drv & ext_val) | (~d & ~ext_drv & exp_pu(d, o, g, p));
  endfunction

  initial begin
    logic [W-1:0] v;
    logic [W-1:0] opat [4];
    bus_we = 0; bus_addr = 0; bus_wdata = 0;
    pud_global = 0; pud_port = 0;
    ext_drv = 0; ext_val = 0;
    rst_n = 1'b1;
    #0.5 rst_n = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    // R1 reset state
    check("R1 oe", pad_oe, '0);
    check("R1 pu", pad_pu, '0);
    bus_read(2'd0, v); check("R1 pin", v, '0);
    bus_read(2'd1, v); check("R1 dir", v, '0);
    bus_read(2'd2, v); check("R1 out", v, '0);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // Sweep: R2 R4 R5 R6 over all directions, several outputs, all disables
    ext_drv = 8'h0F; ext_val = 8'h05;
    for (int gp = 0; gp < 4; gp++) begin
      pud_global = gp[1]; pud_port = gp[0];
      for (int d = 0; d < 256; d++) begin
        opat[0] = 8'h00; opat[1] = 8'hFF; opat[2] = 8'hA5; opat[3] = ~W'(d);
        for (int k = 0; k < 4; k++) begin
          bus_write(2'd1, W'(d));
          bus_write(2'd2, opat[k]);
          check("R4 oe", pad_oe, W'(d));
          check("R4 drive", pad_out, opat[k]);
          check("R5 pullup", pad_pu, exp_pu(W'(d), opat[k], gp[1], gp[0]));
          bus_read(2'd1, v); check("R2 dir readback", v, W'(d));
          bus_read(2'd2, v); check("R2 out readback", v, opat[k]);
          repeat (2) @(posedge clk);
          #1;
          bus_read(2'd0, v);
          check("R6 pin sample", v, exp_pin(W'(d), opat[k], gp[1], gp[0]));
        end
      end
    end
    pud_global = 0; pud_port = 0;
    bus_read(2'd3, v); check("R2 unused addr", v, '0);

    // R3: ignored write coinciding with a pad capture edge
    ext_drv = 8'hFF; ext_val = 8'h00;
    bus_write(2'd1, 8'h3C);
    bus_write(2'd2, 8'h5A);
    repeat (2) @(posedge clk);
    #1;
    ext_val = 8'h81;            // high phase: captured on the write edge
    bus_write(2'd0, 8'hFF);
    check("R3 oe unchanged", pad_oe, 8'h3C);
    bus_read(2'd1, v); check("R3 dir unchanged", v, 8'h3C);
    bus_read(2'd2, v); check("R3 out unchanged", v, 8'h5A);
    bus_read(2'd0, v); check("R3 pin from pad", v, 8'h99);

    // R7: external change timing, all pins undriven
    bus_write(2'd1, 8'h00);
    bus_write(2'd2, 8'h00);
    ext_val = 8'h00;
    repeat (3) @(posedge clk);
    #1;
    ext_val = 8'hC3;            // high phase
    #2;                         // low phase, before next rising edge
    bus_read(2'd0, v); check("R7 high-phase old", v, 8'h00);
    @(posedge clk); #1;
    bus_read(2'd0, v); check("R7 high-phase new", v, 8'hC3);
    @(negedge clk); #0.5;
    ext_val = 8'h3C;            // low phase
    @(posedge clk); #0.5;
    bus_read(2'd0, v); check("R7 low-phase one edge", v, 8'hC3);
    @(posedge clk); #0.5;
    bus_read(2'd0, v); check("R7 low-phase two edges", v, 8'h3C);
    @(posedge clk); #1.8;
    ext_val = 8'h99;            // just before the falling edge
    @(posedge clk); #0.5;
    bus_read(2'd0, v); check("R7 late high-phase", v, 8'h99);

    // R8: software readback through the pin register
    ext_drv = 8'h00;
    bus_write(2'd1, 8'hFF);
    repeat (2) @(posedge clk);
    #1;
    bus_write(2'd2, 8'h6E);
    bus_read(2'd0, v); check("R8 before edge", v, 8'h00);
    @(posedge clk); #1;
    bus_read(2'd0, v); check("R8 after edge", v, 8'h6E);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule